// File: doc/BRIEF.md
# BPSK Carrier Recovery Loop

This block tracks and removes the carrier phase and frequency offset from a stream of complex baseband BPSK symbols so that a coherent slicer can decide each bit. Each symbol arrives with a valid strobe. The block rotates the symbol by the negative of its current phase estimate. The rotation uses a numerically controlled oscillator whose 16-bit phase accumulator addresses a small computed sine table. The residual error comes from a cross-product detector: the rotated Q is multiplied by the sign of the rotated I. A proportional-plus-integral filter then steers the oscillator. Its integrator acts as the frequency estimate, so a constant frequency offset is removed completely, not only a fixed phase.

Two reference modes exist. In blind mode the hard decision on the rotated I gives the reference sign. In aided mode a known preamble bit, supplied beside each symbol, replaces that decision. Aided mode removes the 180-degree ambiguity and shortens acquisition. A freeze input holds all loop state between packets. A small state machine (LK_SEEK, LK_SETTLE, LK_HELD) reports lock from a running average of the error magnitude.

Top module: `bpsk_carrier_loop`

## Requirements
- R1: A synchronous reset clears the phase accumulator, the frequency integrator, the outputs and the lock flag. Immediately after reset, a symbol (x, 0) leaves the block as out_i = (x*127)>>>7 and out_q = 0, with zero rotation.
- R2: out_valid is high exactly in the cycle after a cycle with sym_valid high. The registered outputs change only on such symbols.
- R3: out_bit is 0 when the rotated I is zero or positive and 1 when it is negative. Hard bit 0 stands for a +1 symbol and bit 1 for a -1 symbol.
- R4: In blind mode, a static phase offset within ±90 degrees is removed. After convergence the hard bits equal the sent bits and |out_q| stays below one sixth of the symbol amplitude.
- R5: A constant frequency offset of 0.7 degrees per symbol is tracked without cycle slips. After convergence the hard bits keep one polarity relative to the data over a 200-symbol window.
- R6: In blind mode, an offset beyond 90 degrees (150 degrees) locks to the nearer axis, so the bits are inverted. With aided=1 and known_bit equal to the sent bit (0 = +1, 1 = -1), the same offset locks to the true polarity.
- R7: While freeze is high, the phase accumulator and frequency integrator hold their values. Symbols still pass through with the held rotation.
- R8: Lock asserts after lock_count consecutive unfrozen symbols whose running error average, taken before the symbol, is below lock_thresh. The state machine moves LK_SEEK to LK_SETTLE on the first such symbol, and LK_SETTLE to LK_HELD on the count-th.
- R9: In LK_SETTLE or LK_HELD, one unfrozen symbol with the average at or above lock_thresh returns the machine to LK_SEEK. Lock drops on that symbol.
- R10: kp_shift and ki_shift set the loop gains as right shifts of the error. With both at 15, a 30-degree offset is not removed within 100 symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Hold loop and lock state |
| sym_valid | input | 1 | Input symbol strobe |
| sym_i | input | IN_W | Input in-phase sample, signed |
| sym_q | input | IN_W | Input quadrature sample, signed |
| aided | input | 1 | 1: known_bit gives the reference sign |
| known_bit | input | 1 | Preamble bit for this symbol (0 = +1, 1 = -1) |
| kp_shift | input | 4 | Proportional gain right shift |
| ki_shift | input | 4 | Integral gain right shift |
| lock_thresh | input | IN_W+1 | Lock threshold on the average error magnitude |
| lock_count | input | CNT_W | Symbols below threshold needed for lock |
| out_valid | output | 1 | Output symbol strobe |
| out_i | output | IN_W+1 | Rotated in-phase sample, signed |
| out_q | output | IN_W+1 | Rotated quadrature sample, signed |
| out_bit | output | 1 | Hard decision |
| lock | output | 1 | Lock indicator |

## Verification
Every result of a symbol is due one clock edge after its strobe: the rotated samples, the hard bit, out_valid and the lock flag. The loop state moved by that symbol is first seen by the next symbol. The bench drives a strobe on a falling edge and reads every output on the following falling edge. The lock count and the lock drop are therefore checked on exact symbols. The tracking results (R4 to R6, R10) are judged over windows that start only after a fixed convergence length of several hundred symbols.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [1:0] {
        LK_SEEK   = 2'd0,
        LK_SETTLE = 2'd1,
        LK_HELD   = 2'd2
    } lock_state_t;

    localparam int TBL_BITS = 6;
    localparam int TBL_W    = 8;

    // 17-point quarter wave, amplitude 127, step 90/16 degrees
    function automatic logic signed [TBL_W-1:0] quarter_sine(input logic [4:0] k);
        unique case (k)
            5'd0:  return 8'sd0;
            5'd1:  return 8'sd12;
            5'd2:  return 8'sd25;
            5'd3:  return 8'sd37;
            5'd4:  return 8'sd49;
            5'd5:  return 8'sd60;
            5'd6:  return 8'sd71;
            5'd7:  return 8'sd81;
            5'd8:  return 8'sd90;
            5'd9:  return 8'sd98;
            5'd10: return 8'sd106;
            5'd11: return 8'sd112;
            5'd12: return 8'sd117;
            5'd13: return 8'sd122;
            5'd14: return 8'sd125;
            5'd15: return 8'sd126;
            default: return 8'sd127;
        endcase
    endfunction

    function automatic logic signed [TBL_W-1:0] wave_sine(input logic [TBL_BITS-1:0] idx);
        logic [4:0] k;
        logic [4:0] km;
        k  = {1'b0, idx[3:0]};
        km = 5'd16 - k;
        unique case (idx[5:4])
            2'd0:    return quarter_sine(k);
            2'd1:    return quarter_sine(km);
            2'd2:    return -quarter_sine(k);
            default: return -quarter_sine(km);
        endcase
    endfunction

endpackage

// File: rtl/cr_derotator.sv
module cr_derotator
    import cr_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = IN_W + 1
) (
    input  logic [TBL_BITS-1:0]    idx,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic signed [OUT_W-1:0] rot_i,
    output logic signed [OUT_W-1:0] rot_q
);
    localparam int AW = OUT_W + TBL_W - 1;

    logic signed [TBL_W-1:0] cos_v;
    logic signed [TBL_W-1:0] sin_v;
    logic signed [AW-1:0]    acc_i;
    logic signed [AW-1:0]    acc_q;

    always_comb begin
        sin_v = wave_sine(idx);
        cos_v = wave_sine(idx + TBL_BITS'(16));
        // multiply by exp(-j*theta)
        acc_i = AW'(in_i) * AW'(cos_v) + AW'(in_q) * AW'(sin_v);
        acc_q = AW'(in_q) * AW'(cos_v) - AW'(in_i) * AW'(sin_v);
        rot_i = OUT_W'(acc_i >>> (TBL_W - 1));
        rot_q = OUT_W'(acc_q >>> (TBL_W - 1));
    end
endmodule

// File: rtl/cr_loop_filter.sv
module cr_loop_filter #(
    parameter int ERR_W = 13,
    parameter int PH_W  = 16,
    parameter int FW    = 24,
    parameter int FRAC  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    update,
    input  logic signed [ERR_W-1:0] err,
    input  logic [3:0]              kp_shift,
    input  logic [3:0]              ki_shift,
    output logic [PH_W-1:0]         phase,
    output logic signed [FW-1:0]    freq
);
    logic signed [PH_W-1:0] err_ph;
    logic signed [PH_W-1:0] p_term;
    logic signed [FW-1:0]   i_term;
    logic [PH_W-1:0]        p_bits;
    logic [PH_W-1:0]        f_bits;

    always_comb begin
        err_ph = PH_W'(err);
        p_term = err_ph >>> kp_shift;
        i_term = FW'(err) >>> ki_shift;
        p_bits = p_term;
        f_bits = freq[FRAC +: PH_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            freq  <= '0;
        end else if (update) begin
            freq  <= freq + i_term;
            phase <= phase + f_bits + p_bits;
        end
    end
endmodule

// File: rtl/cr_lock_fsm.sv
module cr_lock_fsm
    import cr_pkg::*;
#(
    parameter int ERR_W  = 13,
    parameter int AVG_SH = 3,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    update,
    input  logic signed [ERR_W-1:0] err,
    input  logic [ERR_W-1:0]        thresh,
    input  logic [CNT_W-1:0]        need_count,
    output logic                    locked,
    output logic [ERR_W-1:0]        avg
);
    localparam int SW = ERR_W + AVG_SH;

    lock_state_t     state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [SW-1:0]    avg_s;
    logic [ERR_W-1:0] mag;
    logic             below;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        mag     = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
        avg     = ERR_W'(avg_s >> AVG_SH);
        below   = avg < thresh;
        cnt_inc = {1'b0, cnt} + 1'b1;
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (update) begin
            unique case (state)
                LK_SEEK: if (below) begin
                    cnt_nx   = CNT_W'(1);
                    state_nx = (need_count <= CNT_W'(1)) ? LK_HELD : LK_SETTLE;
                end
                LK_SETTLE: if (!below) begin
                    state_nx = LK_SEEK;
                end else if (cnt_inc >= {1'b0, need_count}) begin
                    state_nx = LK_HELD;
                end else begin
                    cnt_nx = CNT_W'(cnt_inc);
                end
                LK_HELD: if (!below) state_nx = LK_SEEK;
                default: state_nx = LK_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_SEEK;
            cnt   <= '0;
            avg_s <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (update) avg_s <= avg_s - SW'(avg) + SW'(mag);
        end
    end

    always_comb locked = (state == LK_HELD);
endmodule

// File: rtl/bpsk_carrier_loop.sv
module bpsk_carrier_loop
    import cr_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int PH_W   = 16,
    parameter int FW     = 24,
    parameter int FRAC   = 4,
    parameter int AVG_SH = 3,
    parameter int CNT_W  = 8,
    localparam int OUT_W = IN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    freeze,
    input  logic                    sym_valid,
    input  logic signed [IN_W-1:0]  sym_i,
    input  logic signed [IN_W-1:0]  sym_q,
    input  logic                    aided,
    input  logic                    known_bit,
    input  logic [3:0]              kp_shift,
    input  logic [3:0]              ki_shift,
    input  logic [OUT_W-1:0]        lock_thresh,
    input  logic [CNT_W-1:0]        lock_count,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q,
    output logic                    out_bit,
    output logic                    lock
);
    logic [PH_W-1:0]         phase_acc;
    logic signed [FW-1:0]    freq_acc;
    logic signed [OUT_W-1:0] rot_i, rot_q, pd_err;
    logic [OUT_W-1:0]        err_avg;
    logic                    ref_neg, step;

    cr_derotator #(.IN_W(IN_W), .OUT_W(OUT_W)) u_rot (
        .idx   (phase_acc[PH_W-1 -: TBL_BITS]),
        .in_i  (sym_i),
        .in_q  (sym_q),
        .rot_i (rot_i),
        .rot_q (rot_q)
    );

    // cross-product detector: reference sign times rotated Q
    always_comb begin
        ref_neg = aided ? known_bit : rot_i[OUT_W-1];
        pd_err  = ref_neg ? -rot_q : rot_q;
        step    = sym_valid && !freeze;
    end

    cr_loop_filter #(.ERR_W(OUT_W), .PH_W(PH_W), .FW(FW), .FRAC(FRAC)) u_lf (
        .clk      (clk),
        .rst      (rst),
        .update   (step),
        .err      (pd_err),
        .kp_shift (kp_shift),
        .ki_shift (ki_shift),
        .phase    (phase_acc),
        .freq     (freq_acc)
    );

    cr_lock_fsm #(.ERR_W(OUT_W), .AVG_SH(AVG_SH), .CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .update     (step),
        .err        (pd_err),
        .thresh     (lock_thresh),
        .need_count (lock_count),
        .locked     (lock),
        .avg        (err_avg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= sym_valid;
            if (sym_valid) begin
                out_i   <= rot_i;
                out_q   <= rot_q;
                out_bit <= rot_i[OUT_W-1];
            end
        end
    end
endmodule

// File: rtl/cr_loop_chk.sv
module cr_loop_chk #(
    parameter int OUT_W = 13,
    parameter int PH_W  = 16,
    parameter int FW    = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sym_valid,
    input logic                    freeze,
    input logic                    out_valid,
    input logic                    out_bit,
    input logic                    lock,
    input logic signed [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0]        avg,
    input logic [OUT_W-1:0]        lock_thresh,
    input logic [PH_W-1:0]         phase,
    input logic signed [FW-1:0]    freq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (phase == '0 && freq == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> out_valid);

    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(sym_valid));

    // R3
    hard_bit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bit == (out_i < 0)));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ($stable(phase) && $stable(freq)));

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(sym_valid && !freeze));

    // R9
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && sym_valid && !freeze && avg >= lock_thresh) |=> !lock);
endmodule

bind bpsk_carrier_loop cr_loop_chk #(.OUT_W(OUT_W), .PH_W(PH_W), .FW(FW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sym_valid   (sym_valid),
    .freeze      (freeze),
    .out_valid   (out_valid),
    .out_bit     (out_bit),
    .lock        (lock),
    .out_i       (out_i),
    .avg         (err_avg),
    .lock_thresh (lock_thresh),
    .phase       (phase_acc),
    .freq        (freq_acc)
);

// File: tb/tb_bpsk_carrier_loop.sv
module tb_bpsk_carrier_loop;
    localparam int IN_W = 12;
    localparam int OUT_W = IN_W + 1;
    localparam int AMP = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic freeze = 1'b0, sym_valid = 1'b0, aided = 1'b0, known_bit = 1'b0;
    logic signed [IN_W-1:0] sym_i = '0, sym_q = '0;
    logic [3:0] kp_shift = 4'd1, ki_shift = 4'd3;
    logic [OUT_W-1:0] lock_thresh = OUT_W'(100);
    logic [7:0] lock_count = 8'd5;
    logic out_valid, out_bit, lock;
    logic signed [OUT_W-1:0] out_i, out_q;

    int checks = 0, failures = 0;
    int r_i, r_q, r_bit, r_valid;
    int n_match, n_inv, max_q, min_q;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bpsk_carrier_loop dut (
        .clk(clk), .rst(rst), .freeze(freeze), .sym_valid(sym_valid),
        .sym_i(sym_i), .sym_q(sym_q), .aided(aided), .known_bit(known_bit),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .lock_thresh(lock_thresh),
        .lock_count(lock_count), .out_valid(out_valid), .out_i(out_i),
        .out_q(out_q), .out_bit(out_bit), .lock(lock)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int zero_rot(input int x);
        return (x * 127) >>> 7;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_sym(input int i, input int q, input bit kb);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_i = IN_W'(i);
        sym_q = IN_W'(q);
        known_bit = kb;
        @(negedge clk);
        sym_valid = 1'b0;
        r_valid = int'(out_valid);
        r_i = int'(out_i);
        r_q = int'(out_q);
        r_bit = int'(out_bit);
    endtask

    // rotated BPSK symbol with optional noise; judge the last nchk symbols
    task automatic run_window(input real ph0, input real rate, input int nconv,
                              input int nchk, input int noise);
        n_match = 0; n_inv = 0; max_q = 0; min_q = 1 << 20;
        for (int n = 0; n < nconv + nchk; n++) begin
            bit b;
            real ph, s;
            int ni, nq, aq;
            b = 1'($urandom_range(1));
            s = b ? -1.0 : 1.0;
            ph = (ph0 + rate * n) * 3.14159265358979 / 180.0;
            ni = (noise > 0) ? int'($urandom_range(2 * noise)) - noise : 0;
            nq = (noise > 0) ? int'($urandom_range(2 * noise)) - noise : 0;
            send_sym(rnd(s * AMP * $cos(ph)) + ni, rnd(s * AMP * $sin(ph)) + nq, b);
            if (n >= nconv) begin
                check(r_bit == int'(r_i < 0), "R3", r_bit, int'(r_i < 0));
                if (r_bit == int'(b)) n_match++; else n_inv++;
                aq = (r_q < 0) ? -r_q : r_q;
                if (aq > max_q) max_q = aq;
                if (aq < min_q) min_q = aq;
            end
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(lock == 1'b0, "R1", int'(lock), 0);
        check(out_i == '0, "R1", int'(out_i), 0);
        rst = 1'b0;

        // R1 zero rotation on the real axis, R3 bits, R8 exact lock count
        for (int k = 0; k < 10; k++) begin
            int x;
            x = int'($urandom_range(800)) + 200;
            if ($urandom_range(1) == 1) x = -x;
            send_sym(x, 0, 1'b0);
            check(r_i == zero_rot(x), "R1", r_i, zero_rot(x));
            check(r_q == 0, "R1", r_q, 0);
            check(r_bit == int'(x < 0), "R3", r_bit, int'(x < 0));
            check(r_valid == 1, "R2", r_valid, 1);
            if (k == 3) check(lock == 1'b0, "R8", int'(lock), 0);
            if (k == 4) check(lock == 1'b1, "R8", int'(lock), 1);
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        check(int'(out_i) == r_i, "R2", int'(out_i), r_i);

        // R9 pure quadrature symbols: average rises, lock drops on the second
        send_sym(0, AMP, 1'b0);
        check(lock == 1'b1, "R9", int'(lock), 1);
        send_sym(0, AMP, 1'b0);
        check(lock == 1'b0, "R9", int'(lock), 0);

        // R4 static 30 degrees, blind
        do_reset();
        run_window(30.0, 0.0, 400, 60, 20);
        check(n_match == 60, "R4", n_match, 60);
        check(max_q < AMP / 6, "R4", max_q, AMP / 6);

        // R7 freeze keeps the learned rotation
        freeze = 1'b1;
        repeat (30) @(negedge clk);
        begin
            int q0, i0;
            send_sym(AMP, 0, 1'b0);
            q0 = r_q; i0 = r_i;
            check(q0 < -AMP / 4, "R7", q0, -AMP / 4);
            for (int k = 0; k < 20; k++) begin
                send_sym(AMP, 0, 1'b0);
                check(r_q == q0 && r_i == i0, "R7", r_q, q0);
            end
        end
        freeze = 1'b0;

        // R6 150 degrees: blind locks inverted, aided locks true
        do_reset();
        run_window(150.0, 0.0, 400, 60, 20);
        check(n_inv == 60, "R6", n_inv, 60);
        do_reset();
        aided = 1'b1;
        run_window(150.0, 0.0, 400, 60, 20);
        check(n_match == 60, "R6", n_match, 60);
        aided = 1'b0;

        // R5 frequency offset, no slips over the window; R8 locked
        do_reset();
        run_window(0.0, 0.703125, 800, 200, 20);
        check(n_match == 200 || n_inv == 200, "R5", n_match, 200);
        check(max_q < AMP / 6, "R5", max_q, AMP / 6);
        check(lock == 1'b1, "R8", int'(lock), 1);

        // R10 minimal gains leave the offset in place
        do_reset();
        kp_shift = 4'd15; ki_shift = 4'd15;
        run_window(30.0, 0.0, 80, 20, 0);
        check(min_q > AMP / 4, "R10", min_q, AMP / 4);
        kp_shift = 4'd1; ki_shift = 4'd3;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule